// File: doc/BRIEF.md
# Multiprecision ALU with Flags

This block is a registered 16-bit two's-complement arithmetic and logic unit built for word-serial multiprecision work. Two input registers, each with an active-low clock enable, capture the external A and B operands. Operand multiplexers pick each ALU input from those registers or from two result registers, called left and right, that feed back. A 5-bit opcode picks one of 32 operations. The opcode, operand selects, register control, carry-in and a first-word marker are all captured on the same rising edge. The operation runs during the cycle that starts at that edge, and its result is written at the following edge.

Long operands are processed least-significant word first, one 16-bit word per cycle. The carry-out of each cycle is held in a one-bit carry register. The next word uses that register as its carry input unless it is marked as the first word, in which case the external carry-in is used. A sticky zero flag reports whether every word of the extended result was zero. A block-floating-point flag reports growth into the sign region of the result. Four dedicated opcodes set how that growth is judged, and while one of them runs the ALU output is zero.

Top module: `mp_alu`

## Requirements
- R1: The A input register loads `a_in` at a rising edge only when `a_ce_n` is low, and the B input register loads `b_in` only when `b_ce_n` is low. When an enable is high, its register keeps its value.
- R2: The opcode, both operand selects, `reg_ctl`, `carry_in` and `first_word` are captured at a rising edge together with the operands. The result of that operation is written at the next rising edge, which gives a latency of two edges from the inputs to `result`.
- R3: Operand A is chosen by `a_sel`: 0 is the A register, 1 is left, 2 is right, 3 is zero. Operand B is chosen by `b_sel`: 0 is the B register, 1 is left.
- R4: The arithmetic opcodes 0x00–0x0F are pairs. Opcode bits [3:1] select the computation: 0 is A+B, 1 is A+~B, 2 is ~A+B, 3 is A, 4 is ~A, 5 is B, 6 is ~B, 7 is A+0xFFFF. An even code adds the selected carry. An odd code forces the carry to 1, so 0x03 is A−B, 0x05 is B−A, 0x07 is A+1 and 0x09 is −A. The carry-out is bit 16 of the sum.
- R5: The logic opcodes 0x10–0x1B compute, in order: AND, OR, XOR, ~A, ~B, A, B, NAND, NOR, XNOR, A&~B, and zero. Their carry-out is 0.
- R6: When `first_word` is 1, the selected carry is `carry_in`. Otherwise it is the carry register, which holds the carry-out of the previous cycle. `carry_out` shows that register.
- R7: The zero flag becomes (result==0) on a first-word cycle. On any other cycle it becomes the AND of its old value and (result==0).
- R8: Opcodes 0x1C–0x1F write 0 to the result and load the flag mode with opcode bits [1:0]. The new mode applies from the next operation onward. `bfp_flag` is computed with the mode in force during the operation. In mode m<3, `bfp_flag` is set when the top m+2 result bits are not all equal. In mode 3, `bfp_flag` is set on signed overflow of an arithmetic opcode.
- R9: `reg_ctl[0]` writes the result into left, and `reg_ctl[1]` writes it into right. `reg_ctl[2]` selects which of the two drives `result` (0 is left, 1 is right). An unwritten register keeps its value.
- R10: A 32-bit or 64-bit addition or subtraction run as 2 or 4 back-to-back word cycles gives the full-width sum or difference. It also gives the final carry, and a zero flag that is true only for an all-zero result.
- R11: After reset, `result`, `carry_out`, `zero_flag` and `bfp_flag` are 0, and the flag mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 16 | External A operand |
| b_in | input | 16 | External B operand |
| a_ce_n | input | 1 | A register load enable, active low |
| b_ce_n | input | 1 | B register load enable, active low |
| a_sel | input | 2 | Operand A source select |
| b_sel | input | 1 | Operand B source select |
| opcode | input | 5 | Operation code |
| reg_ctl | input | 3 | Result register write enables and output select |
| carry_in | input | 1 | External carry for first words |
| first_word | input | 1 | Marks the least-significant word of a sequence |
| result | output | 16 | Selected result register |
| carry_out | output | 1 | Carry register |
| zero_flag | output | 1 | Sticky zero flag |
| bfp_flag | output | 1 | Block-floating-point growth flag |

## Verification
The hardest state to reach is a carry that crosses word boundaries while the sticky zero flag stays meaningful. To reach it, each word of a long operand must be issued on consecutive edges with no idle cycle between them, because any intervening operation overwrites the carry register. The bench streams 2-word and 4-word additions and subtractions with operands that ripple a carry through every word, such as all-ones plus one and equal minuend and subtrahend. It collects the words as they emerge two edges later and checks the last carry and the zero flag before the next operation overwrites them. A long pseudo-random run across all 32 opcodes, all operand selects and both enables is also checked against the cycle-level model on every clock.

// File: rtl/mp_alu_pkg.sv
package mp_alu_pkg;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned RCTL_W = 3;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [1:0] {
    ASRC_AREG  = 2'd0,
    ASRC_LEFT  = 2'd1,
    ASRC_RIGHT = 2'd2,
    ASRC_ZERO  = 2'd3
  } asrc_e;

  typedef enum logic {
    BSRC_BREG = 1'b0,
    BSRC_LEFT = 1'b1
  } bsrc_e;

  typedef enum logic [3:0] {
    LG_AND  = 4'd0,  LG_OR   = 4'd1,  LG_XOR  = 4'd2,  LG_NOTA = 4'd3,
    LG_NOTB = 4'd4,  LG_PASA = 4'd5,  LG_PASB = 4'd6,  LG_NAND = 4'd7,
    LG_NOR  = 4'd8,  LG_XNOR = 4'd9,  LG_ANDN = 4'd10, LG_ZERO = 4'd11
  } logic_op_e;

  typedef struct packed {
    logic [1:0] a_sel;
    logic       b_sel;
    logic [4:0] opcode;
    logic [2:0] reg_ctl;
    logic       carry_in;
    logic       first_word;
  } ctl_t;
endpackage

// File: rtl/mp_alu_opsel.sv
module mp_alu_opsel
  import mp_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_q,
  input  logic [W-1:0] b_q,
  input  logic [W-1:0] left_q,
  input  logic [W-1:0] right_q,
  input  logic [1:0]   a_sel,
  input  logic         b_sel,
  output logic [W-1:0] opa,
  output logic [W-1:0] opb
);
  always_comb begin
    unique case (asrc_e'(a_sel))
      ASRC_AREG:  opa = a_q;
      ASRC_LEFT:  opa = left_q;
      ASRC_RIGHT: opa = right_q;
      default:    opa = '0;
    endcase
  end

  assign opb = (bsrc_e'(b_sel) == BSRC_LEFT) ? left_q : b_q;
endmodule

// File: rtl/mp_alu_core.sv
module mp_alu_core
  import mp_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [OP_W-1:0] op,
  input  logic          carry_sel,
  output logic [W-1:0]  res,
  output logic          cout,
  output logic          ovf,
  output logic          flag_op,
  output logic          carry_used
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  function automatic logic [W:0] add_word(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [W-1:0] logic_fn(input logic [3:0] sel,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    case (logic_op_e'(sel))
      LG_AND:  return a & b;
      LG_OR:   return a | b;
      LG_XOR:  return a ^ b;
      LG_NOTA: return ~a;
      LG_NOTB: return ~b;
      LG_PASA: return a;
      LG_PASB: return b;
      LG_NAND: return ~(a & b);
      LG_NOR:  return ~(a | b);
      LG_XNOR: return ~(a ^ b);
      LG_ANDN: return a & ~b;
      default: return '0;
    endcase
  endfunction

  logic [W-1:0] x, y;
  logic [W:0]   sum;
  logic         is_arith;

  assign is_arith = ~op[4];

  always_comb begin
    case (op[3:1])
      3'd0: begin x = opa;  y = opb;  end
      3'd1: begin x = opa;  y = ~opb; end
      3'd2: begin x = ~opa; y = opb;  end
      3'd3: begin x = opa;  y = '0;   end
      3'd4: begin x = ~opa; y = '0;   end
      3'd5: begin x = opb;  y = '0;   end
      3'd6: begin x = ~opb; y = '0;   end
      default: begin x = opa; y = ONES; end
    endcase
  end

  assign carry_used = op[0] ? 1'b1 : carry_sel;
  assign sum        = add_word(x, y, carry_used);

  always_comb begin
    res     = '0;
    cout    = 1'b0;
    ovf     = 1'b0;
    flag_op = 1'b0;
    if (is_arith) begin
      res  = sum[W-1:0];
      cout = sum[W];
      ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end else if (op[3:2] == 2'b11) begin
      flag_op = 1'b1;
    end else begin
      res = logic_fn(op[3:0], opa, opb);
    end
  end
endmodule

// File: rtl/mp_alu_flags.sv
module mp_alu_flags
  import mp_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      res,
  input  logic              cout,
  input  logic              ovf,
  input  logic              flag_op,
  input  logic [MODE_W-1:0] new_mode,
  input  logic              first_word,
  output logic              carry_q,
  output logic              zero_q,
  output logic              bfp_q,
  output logic [MODE_W-1:0] mode_q
);
  localparam int unsigned MODES = 1 << MODE_W;

  function automatic logic top_mixed(input logic [W-1:0] r, input int unsigned n);
    logic m;
    m = 1'b0;
    for (int unsigned k = 1; k < n; k++) begin
      if (r[W-1-k] != r[W-1]) m = 1'b1;
    end
    return m;
  endfunction

  logic [MODES-1:0] detect;
  logic             res_zero;

  genvar g;
  generate
    for (g = 0; g < MODES; g++) begin : g_mode
      if (g == MODES - 1) begin : g_ovf
        assign detect[g] = ovf;
      end else begin : g_grow
        assign detect[g] = top_mixed(res, g + 2);
      end
    end
  endgenerate

  assign res_zero = (res == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
      bfp_q   <= 1'b0;
      mode_q  <= '0;
    end else begin
      carry_q <= cout;
      zero_q  <= res_zero & (first_word | zero_q);
      bfp_q   <= detect[mode_q];
      if (flag_op) mode_q <= new_mode;
    end
  end
endmodule

// File: rtl/mp_alu.sv
module mp_alu
  import mp_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         a_ce_n,
  input  logic         b_ce_n,
  input  logic [1:0]   a_sel,
  input  logic         b_sel,
  input  logic [4:0]   opcode,
  input  logic [2:0]   reg_ctl,
  input  logic         carry_in,
  input  logic         first_word,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero_flag,
  output logic         bfp_flag
);
  logic [W-1:0] a_q, b_q, left_q, right_q;
  logic         osel_q;
  ctl_t         ctl_q;
  logic [W-1:0] opa, opb, alu_res;
  logic         alu_cout, alu_ovf, flag_op, carry_used, carry_sel;
  logic [MODE_W-1:0] mode_q;
  logic [4:0]   op_q;
  logic [2:0]   rctl_q;
  logic         fw_q;

  // Input capture: operands under enable, controls every edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      ctl_q <= '0;
    end else begin
      if (!a_ce_n) a_q <= a_in;
      if (!b_ce_n) b_q <= b_in;
      ctl_q <= '{a_sel: a_sel, b_sel: b_sel, opcode: opcode, reg_ctl: reg_ctl,
                 carry_in: carry_in, first_word: first_word};
    end
  end

  assign op_q   = ctl_q.opcode;
  assign rctl_q = ctl_q.reg_ctl;
  assign fw_q   = ctl_q.first_word;

  mp_alu_opsel #(.W(W)) u_opsel (
    .a_q(a_q), .b_q(b_q), .left_q(left_q), .right_q(right_q),
    .a_sel(ctl_q.a_sel), .b_sel(ctl_q.b_sel), .opa(opa), .opb(opb)
  );

  assign carry_sel = fw_q ? ctl_q.carry_in : carry_out;

  mp_alu_core #(.W(W)) u_core (
    .opa(opa), .opb(opb), .op(op_q), .carry_sel(carry_sel),
    .res(alu_res), .cout(alu_cout), .ovf(alu_ovf),
    .flag_op(flag_op), .carry_used(carry_used)
  );

  mp_alu_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .res(alu_res), .cout(alu_cout), .ovf(alu_ovf),
    .flag_op(flag_op), .new_mode(op_q[MODE_W-1:0]), .first_word(fw_q),
    .carry_q(carry_out), .zero_q(zero_flag), .bfp_q(bfp_flag), .mode_q(mode_q)
  );

  // Result register pair
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      osel_q  <= 1'b0;
    end else begin
      if (rctl_q[0]) left_q  <= alu_res;
      if (rctl_q[1]) right_q <= alu_res;
      osel_q <= rctl_q[2];
    end
  end

  assign result = osel_q ? right_q : left_q;
endmodule

// File: rtl/mp_alu_chk.sv
module mp_alu_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a_ce_n,
  input logic [W-1:0] a_q,
  input logic [W-1:0] left_q,
  input logic [W-1:0] right_q,
  input logic [2:0]   rctl_q,
  input logic [4:0]   op_q,
  input logic         fw_q,
  input logic [W-1:0] alu_res,
  input logic         alu_cout,
  input logic         flag_op,
  input logic         carry_out,
  input logic         zero_flag
);
  assert_ce_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    a_ce_n |=> $stable(a_q));

  assert_writeback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rctl_q[0] |=> (left_q == $past(alu_res)));

  assert_logic_nocarry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_q[4] |-> !alu_cout);

  assert_carry_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (carry_out == $past(alu_cout)));

  assert_zero_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw_q && !zero_flag) |=> !zero_flag);

  assert_flagop_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_op |-> (alu_res == '0));

  assert_right_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rctl_q[1] |=> $stable(right_q));
endmodule

bind mp_alu mp_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_ce_n(a_ce_n), .a_q(a_q), .left_q(left_q),
  .right_q(right_q), .rctl_q(rctl_q), .op_q(op_q), .fw_q(fw_q),
  .alu_res(alu_res), .alu_cout(alu_cout), .flag_op(flag_op),
  .carry_out(carry_out), .zero_flag(zero_flag)
);

// File: tb/tb_mp_alu.sv
module tb_mp_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_in = '0, b_in = '0;
  logic        a_ce_n = 1'b1, b_ce_n = 1'b1;
  logic [1:0]  a_sel = '0;
  logic        b_sel = 1'b0;
  logic [4:0]  opcode = 5'h15;
  logic [2:0]  reg_ctl = '0;
  logic        carry_in = 1'b0, first_word = 1'b1;
  logic [15:0] result;
  logic        carry_out, zero_flag, bfp_flag;

  int vectors = 0, errors = 0;
  bit done = 1'b0;
  bit osel_cur = 1'b0;

  always #10 clk = ~clk;

  mp_alu dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .a_ce_n(a_ce_n),
    .b_ce_n(b_ce_n), .a_sel(a_sel), .b_sel(b_sel), .opcode(opcode),
    .reg_ctl(reg_ctl), .carry_in(carry_in), .first_word(first_word),
    .result(result), .carry_out(carry_out), .zero_flag(zero_flag),
    .bfp_flag(bfp_flag)
  );

  // ---------------- behavioural reference model ----------------
  int m_a, m_b, m_left, m_right, m_osel, m_carry, m_zero, m_bfp, m_mode;
  int q_asel, q_bsel, q_op, q_rctl, q_cin, q_fw;

  task automatic ref_exec(input int op, input int a, input int b, input int c,
                          output int r, output int co, output int v);
    int x, y, s, sx, sy;
    r = 0; co = 0; v = 0; x = 0; y = 0;
    if (op < 16) begin
      case (op / 2)
        0: begin x = a; y = b; end
        1: begin x = a; y = 65535 - b; end
        2: begin x = 65535 - a; y = b; end
        3: begin x = a; y = 0; end
        4: begin x = 65535 - a; y = 0; end
        5: begin x = b; y = 0; end
        6: begin x = 65535 - b; y = 0; end
        default: begin x = a; y = 65535; end
      endcase
      if (op % 2 == 1) c = 1;
      s  = x + y + c;
      r  = s % 65536;
      co = s / 65536;
      sx = (x >= 32768) ? x - 65536 : x;
      sy = (y >= 32768) ? y - 65536 : y;
      s  = sx + sy + c;
      v  = (s > 32767 || s < -32768) ? 1 : 0;
    end else if (op < 28) begin
      case (op - 16)
        0: r = a & b;
        1: r = a | b;
        2: r = a ^ b;
        3: r = 65535 - a;
        4: r = 65535 - b;
        5: r = a;
        6: r = b;
        7: r = 65535 - (a & b);
        8: r = 65535 - (a | b);
        9: r = 65535 - (a ^ b);
        10: r = a & (65535 - b);
        default: r = 0;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_left = 0; m_right = 0; m_osel = 0;
      m_carry = 0; m_zero = 0; m_bfp = 0; m_mode = 0;
      q_asel = 0; q_bsel = 0; q_op = 0; q_rctl = 0; q_cin = 0; q_fw = 0;
    end else begin
      int oa, ob, c, r, co, v, top;
      case (q_asel)
        0: oa = m_a; 1: oa = m_left; 2: oa = m_right; default: oa = 0;
      endcase
      ob = q_bsel ? m_left : m_b;
      c  = q_fw ? q_cin : m_carry;
      ref_exec(q_op, oa, ob, c, r, co, v);
      if (m_mode == 3) m_bfp = v;
      else begin
        top   = r >> (14 - m_mode);
        m_bfp = (top == 0 || top == (1 << (m_mode + 2)) - 1) ? 0 : 1;
      end
      m_zero  = (r == 0 && (q_fw == 1 || m_zero == 1)) ? 1 : 0;
      m_carry = co;
      if (q_op >= 28) m_mode = q_op - 28;
      if (q_rctl % 2 == 1) m_left = r;
      if ((q_rctl / 2) % 2 == 1) m_right = r;
      m_osel = q_rctl / 4;
      if (!a_ce_n) m_a = a_in;
      if (!b_ce_n) m_b = b_in;
      q_asel = a_sel; q_bsel = b_sel; q_op = opcode; q_rctl = reg_ctl;
      q_cin = carry_in; q_fw = first_word;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare model with the block on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R9 result", result, (m_osel == 1) ? m_right : m_left);
      chk("R6 carry_out", carry_out, m_carry);
      chk("R7 zero_flag", zero_flag, m_zero);
      chk("R8 bfp_flag", bfp_flag, m_bfp);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic ace, input logic bce, input logic [1:0] as,
                       input logic bs, input logic [4:0] op, input logic [2:0] rc,
                       input logic ci, input logic fw);
    a_in = a; b_in = b; a_ce_n = ace; b_ce_n = bce; a_sel = as; b_sel = bs;
    opcode = op; reg_ctl = rc; carry_in = ci; first_word = fw;
    osel_cur = rc[2];
  endtask

  task automatic idle();
    drive(16'h0, 16'h0, 1'b1, 1'b1, 2'd0, 1'b0, 5'h15, {osel_cur, 2'b00}, 1'b0, 1'b1);
  endtask

  // issue one op (at a negedge), then return at the negedge where it is visible
  task automatic one(input logic [15:0] a, input logic [15:0] b, input logic ace,
                     input logic bce, input logic [1:0] as, input logic bs,
                     input logic [4:0] op, input logic [2:0] rc, input logic ci,
                     input logic fw);
    drive(a, b, ace, bce, as, bs, op, rc, ci, fw);
    @(negedge clk); idle();
    @(negedge clk);
  endtask

  task automatic multi(input int n, input logic [63:0] x, input logic [63:0] y,
                       input bit sub, input string tag);
    logic [63:0] got, mask, exp;
    logic [64:0] full;
    got  = '0;
    mask = (n == 4) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (16 * n)) - 1);
    full = sub ? ({1'b0, x & mask} + {1'b0, ~y & mask} + 65'd1)
               : ({1'b0, x & mask} + {1'b0, y & mask});
    exp  = full[63:0] & mask;
    for (int i = 0; i <= n + 1; i++) begin
      if (i >= 2) got[16*(i-2) +: 16] = result;
      if (i == n + 1) begin
        chk({tag, " R10 value"}, got & mask, exp);
        chk({tag, " R10 carry"}, carry_out, (n == 4) ? full[64] : full[16*n]);
        chk({tag, " R7 zero"}, zero_flag, (exp == 0) ? 1 : 0);
      end
      if (i < n)
        drive(x[16*i +: 16], y[16*i +: 16], 1'b0, 1'b0, 2'd0, 1'b0,
              sub ? ((i == 0) ? 5'h03 : 5'h02) : 5'h00, 3'b001, 1'b0, (i == 0));
      else idle();
      @(negedge clk);
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1'b1;
      vectors++; errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    idle();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 result", result, 0);
    chk("R11 carry", carry_out, 0);
    chk("R11 zero", zero_flag, 0);
    chk("R11 bfp", bfp_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 latency: visible only after the second edge
    drive(16'h1234, 16'h0, 1'b0, 1'b1, 2'd0, 1'b0, 5'h15, 3'b001, 1'b0, 1'b1);
    @(negedge clk); idle();
    chk("R2 not yet", result, 16'h0000);
    @(negedge clk);
    chk("R2 pass A", result, 16'h1234);

    // R1 enable high ignores the new value
    one(16'hBEEF, 16'h0, 1'b1, 1'b1, 2'd0, 1'b0, 5'h15, 3'b001, 1'b0, 1'b1);
    chk("R1 a hold", result, 16'h1234);
    one(16'h0, 16'h00F0, 1'b1, 1'b0, 2'd0, 1'b0, 5'h16, 3'b001, 1'b0, 1'b1);
    one(16'h0, 16'hAAAA, 1'b1, 1'b1, 2'd0, 1'b0, 5'h16, 3'b001, 1'b0, 1'b1);
    chk("R1 b hold", result, 16'h00F0);

    // R3 operand selects and R9 register pair
    one(16'h0, 16'h0, 1'b1, 1'b1, 2'd1, 1'b0, 5'h15, 3'b110, 1'b0, 1'b1);
    chk("R3 a=left into right", result, 16'h00F0);
    one(16'h0, 16'h0, 1'b1, 1'b1, 2'd3, 1'b0, 5'h15, 3'b001, 1'b0, 1'b1);
    chk("R3 a=zero", result, 16'h0000);
    one(16'h0, 16'h0, 1'b1, 1'b1, 2'd2, 1'b0, 5'h15, 3'b001, 1'b0, 1'b1);
    chk("R3 a=right", result, 16'h00F0);
    one(16'h0, 16'h0, 1'b1, 1'b1, 2'd0, 1'b0, 5'h15, 3'b100, 1'b0, 1'b1);
    chk("R9 select right", result, 16'h00F0);

    // R4 arithmetic variants
    one(16'h0005, 16'h0007, 1'b0, 1'b0, 2'd0, 1'b0, 5'h03, 3'b001, 1'b0, 1'b1);
    chk("R4 A-B", result, 16'hFFFE);
    chk("R4 A-B borrow", carry_out, 0);
    one(16'h0005, 16'h0007, 1'b1, 1'b1, 2'd0, 1'b0, 5'h05, 3'b001, 1'b0, 1'b1);
    chk("R4 B-A", result, 16'h0002);
    one(16'h0005, 16'h0007, 1'b1, 1'b1, 2'd0, 1'b0, 5'h09, 3'b001, 1'b0, 1'b1);
    chk("R4 negate A", result, 16'hFFFB);

    // R5 logic
    one(16'hF0F0, 16'hFF00, 1'b0, 1'b0, 2'd0, 1'b0, 5'h12, 3'b001, 1'b0, 1'b1);
    chk("R5 xor", result, 16'h0FF0);
    chk("R5 carry zero", carry_out, 0);

    // R6 carry register used on a continuing word
    drive(16'hFFFF, 16'h0001, 1'b0, 1'b0, 2'd0, 1'b0, 5'h00, 3'b001, 1'b0, 1'b1);
    @(negedge clk);
    drive(16'h0000, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 5'h00, 3'b001, 1'b0, 1'b0);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R6 chained carry", result, 16'h0001);
    one(16'h0001, 16'h0001, 1'b0, 1'b0, 2'd0, 1'b0, 5'h00, 3'b001, 1'b1, 1'b1);
    chk("R6 external carry", result, 16'h0003);

    // R8 flag mode 1: 0x2000 counts as growth, and the flag op itself yields 0
    one(16'h1111, 16'h0, 1'b0, 1'b1, 2'd0, 1'b0, 5'h1D, 3'b001, 1'b0, 1'b1);
    chk("R8 forced zero", result, 16'h0000);
    one(16'h2000, 16'h0, 1'b0, 1'b1, 2'd0, 1'b0, 5'h15, 3'b001, 1'b0, 1'b1);
    chk("R8 mode1 growth", bfp_flag, 1);
    one(16'h0, 16'h0, 1'b1, 1'b1, 2'd0, 1'b0, 5'h1C, 3'b001, 1'b0, 1'b1);
    one(16'h2000, 16'h0, 1'b0, 1'b1, 2'd0, 1'b0, 5'h15, 3'b001, 1'b0, 1'b1);
    chk("R8 mode0 no growth", bfp_flag, 0);
    one(16'h0, 16'h0, 1'b1, 1'b1, 2'd0, 1'b0, 5'h1F, 3'b001, 1'b0, 1'b1);
    one(16'h7FFF, 16'h0001, 1'b0, 1'b0, 2'd0, 1'b0, 5'h00, 3'b001, 1'b0, 1'b1);
    chk("R8 mode3 overflow", bfp_flag, 1);

    // R10 multiprecision against full width
    multi(2, 64'h0000_0000_1234_FFFF, 64'h0000_0000_0001_0001, 1'b0, "add32");
    multi(2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, "add32 wrap");
    multi(2, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001, 1'b1, "sub32");
    multi(4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, "add64 wrap");
    multi(4, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b1, "sub64");
    multi(4, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1'b1, "sub64 zero");
    multi(4, 64'h0001_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0, "add64 hiword");

    // pseudo-random sweep, checked by the model every clock
    lcg = 32'h1ACE_0001;
    for (int k = 0; k < 2000; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      drive(lcg[31:16], lcg[15:0] ^ lcg[31:16], lcg[3], lcg[9], lcg[5:4],
            lcg[12], lcg[22:18], lcg[27:25], lcg[7], lcg[28] | lcg[29]);
      @(negedge clk);
    end
    idle();
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule